// File: doc/BRIEF.md
# Touch-Memory Command Engine

This block is the byte-level command layer of a single-wire touch-memory device. A bit-level line interface, not part of this block, turns wire slots into bytes. It reports each received byte with a one-cycle valid strobe. It asks for the next byte to send with a one-cycle request. It signals with a one-cycle pulse that a bus reset pulse was seen on the line. The engine holds an 8-byte identity value, a 32-byte staging pad, a 512-byte data store and a 5-byte clock counter that advances on a free-running 256 Hz tick.

After every bus reset the engine takes exactly one addressing command and then one memory command. Writes never go straight to the data store. The host first fills the staging pad. It then issues a copy command, and that command must repeat the two target address bytes and the final pad offset as an authorization code. Only a full match commits the pad contents, and one write to the pad arms exactly one successful copy. Until the first bus reset, and after any rejected or unknown command, the engine is idle: it ignores received bytes and offers 0xFF.

Top module: `onewire_cmd_engine`

## Requirements
- R1: After `rst_n` and before any `bus_rst` the engine is idle. A `bus_rst` pulse in any state makes the next received byte be decoded as an addressing command.
- R2: Addressing code 0x33 sends the 8 identity bytes, most significant byte first (`ID_VALUE[63:56]` down to `[7:0]`), and then the engine decodes a memory command.
- R3: Addressing code 0x55 compares the next 8 received bytes with the identity bytes in the same order and goes idle on the first mismatch. Code 0xCC goes straight to memory command decoding.
- R4: Any other addressing code, and any memory code other than 0xF0, 0x0F, 0xAA or 0x55, makes the engine idle until the next `bus_rst`. While idle, received bytes are ignored and `tx_byte` is 0xFF.
- R5: Memory code 0xF0 takes a low and then a high address byte and streams bytes from that address, which increments after each byte. Addresses 0x000–0x1FF return the data store, 0x202–0x206 return clock bytes 0–4, and other addresses below 0x21F return 0x00.
- R6: From address 0x21F upward the read stream returns 0xFF and the address stops advancing.
- R7: Memory code 0x0F takes the low and high target bytes, then stores each following byte in the pad at an offset that starts at 0 and wraps modulo 32. The last offset written becomes the end offset (0 if no byte follows). This command arms one copy.
- R8: Memory code 0xAA sends the target low byte, the target high byte and the end offset, then pad bytes 0 through the end offset, then 0xFF.
- R9: Memory code 0x55 takes three bytes. When they equal the target low byte, target high byte and end offset and a copy is armed, pad bytes 0..end are written to target+0..target+end. Addresses below 0x200 go to the data store, 0x202–0x206 go to the clock, and all others are dropped.
- R10: After a copy command the first requested byte is 0xFF on success and 0x00 on rejection. Every later byte in that session is 0x00.
- R11: A successful copy disarms the pad, so a repeated copy without a new pad write is rejected and writes nothing.
- R12: The 40-bit clock, with byte 0 least significant, adds one on each `tick` pulse, and the carry ripples through all bytes. A copy write to a clock byte takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle pulse: reset pulse detected on the line |
| rx_vld | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte, least significant bit first on the wire |
| tx_req | input | 1 | One-cycle strobe: the line interface takes `tx_byte` now |
| tx_byte | output | 8 | Byte currently offered for sending |
| tick | input | 1 | One-cycle pulse at 256 Hz |

## Verification
A wrong sequencer state shows up at `tx_byte` on the very next request. The engine either falls idle and returns 0xFF where data was due, or it keeps answering after a command that should have silenced it. A corrupted pad offset or target register shows within the three header bytes of a pad read, or in the position of the data that a copy commits. That data is visible in a later memory read of the same session sequence. A broken clock carry only appears when lower bytes roll over, so the bench loads the counter to an all-ones pattern and reads it back one tick later.

// File: rtl/owe_pkg.sv
package owe_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_ROMCMD,
    S_RDROM,
    S_MTROM,
    S_MEMCMD,
    S_TA1,
    S_TA2,
    S_RDMEM,
    S_WRPAD,
    S_TXA1,
    S_TXA2,
    S_TXEND,
    S_RDPAD,
    S_AU1,
    S_AU2,
    S_AU3,
    S_COPY,
    S_CPST
  } eng_state_e;

  localparam logic [7:0] OP_ROM_READ  = 8'h33;
  localparam logic [7:0] OP_ROM_MATCH = 8'h55;
  localparam logic [7:0] OP_ROM_SKIP  = 8'hCC;
  localparam logic [7:0] OP_MEM_READ  = 8'hF0;
  localparam logic [7:0] OP_PAD_WRITE = 8'h0F;
  localparam logic [7:0] OP_PAD_READ  = 8'hAA;
  localparam logic [7:0] OP_PAD_COPY  = 8'h55;

endpackage

// File: rtl/owe_byte_ram.sv
module owe_byte_ram #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/owe_rtc_counter.sv
module owe_rtc_counter #(
  parameter int NBYTES = 5,
  localparam int IW = $clog2(NBYTES),
  localparam int W  = 8 * NBYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  output logic [W-1:0]  value
);

  // carry[g] : byte g must increment this cycle
  logic [NBYTES-1:0] carry;

  assign carry[0] = tick & ~we;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] cur;
    logic [7:0] nxt;
    logic       sel;
    logic       en;

    assign sel = we && (widx == IW'(g));
    assign en  = sel || carry[g];

    always_comb begin
      if (sel) nxt = wdata;
      else     nxt = cur + 8'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cur <= 8'h00;
      else if (en) cur <= nxt;
    end

    assign value[8*g +: 8] = cur;

    if (g < NBYTES - 1) begin : g_carry
      assign carry[g+1] = carry[g] & (cur == 8'hFF);
    end
  end

endmodule

// File: rtl/onewire_cmd_engine.sv
module onewire_cmd_engine
  import owe_pkg::*;
#(
  parameter logic [63:0] ID_VALUE  = 64'h2A5B17C39904E16F,
  parameter int          MEM_BYTES = 512,
  parameter int          PAD_BYTES = 32,
  parameter int          RTC_BYTES = 5,
  parameter logic [15:0] RTC_BASE  = 16'h0202,
  parameter logic [15:0] STOP_ADDR = 16'h021F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic [7:0] tx_byte,
  input  logic       tick
);

  localparam int MEM_AW = $clog2(MEM_BYTES);
  localparam int PAD_AW = $clog2(PAD_BYTES);
  localparam int RTC_IW = $clog2(RTC_BYTES);
  localparam int RTC_W  = 8 * RTC_BYTES;
  localparam logic [15:0] MEM_LIMIT = 16'(MEM_BYTES);
  localparam logic [15:0] RTC_LIMIT = RTC_BASE + 16'(RTC_BYTES);

  eng_state_e        st, st_d;
  logic [2:0]        rom_idx, rom_idx_d;
  logic [15:0]       ptr, ptr_d;
  logic [7:0]        ta1, ta1_d, ta2, ta2_d;
  logic [PAD_AW-1:0] end_ofs, end_ofs_d, wofs, wofs_d;
  logic              op_rd, op_rd_d;
  logic              armed, armed_d;
  logic              auth_ok, auth_ok_d;
  logic              pad_done, pad_done_d;

  logic              rx_go, tx_go;
  logic [7:0]        pad_rdata, ram_rdata, rom_byte, mem_byte;
  logic [15:0]       cp_addr, rtc_rel;
  logic              ram_we, rtc_we, pad_we;
  logic [RTC_W-1:0]  rtc_val;

  assign rx_go   = rx_vld & ~bus_rst;
  assign tx_go   = tx_req & ~bus_rst;
  assign cp_addr = {ta2, ta1} + 16'(ptr[PAD_AW-1:0]);
  assign rtc_rel = ptr - RTC_BASE;

  // ---------------- storage ----------------
  assign pad_we = (st == S_WRPAD) && rx_go;
  assign ram_we = (st == S_COPY) && (cp_addr < MEM_LIMIT);
  assign rtc_we = (st == S_COPY) && (cp_addr >= RTC_BASE) && (cp_addr < RTC_LIMIT);

  owe_byte_ram #(.DEPTH(PAD_BYTES)) u_pad (
    .clk   (clk),
    .we    (pad_we),
    .waddr (wofs),
    .wdata (rx_byte),
    .raddr (ptr[PAD_AW-1:0]),
    .rdata (pad_rdata)
  );

  owe_byte_ram #(.DEPTH(MEM_BYTES)) u_store (
    .clk   (clk),
    .we    (ram_we),
    .waddr (cp_addr[MEM_AW-1:0]),
    .wdata (pad_rdata),
    .raddr (ptr[MEM_AW-1:0]),
    .rdata (ram_rdata)
  );

  owe_rtc_counter #(.NBYTES(RTC_BYTES)) u_rtc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .we    (rtc_we),
    .widx  (RTC_IW'(cp_addr - RTC_BASE)),
    .wdata (pad_rdata),
    .value (rtc_val)
  );

  // ---------------- read-side muxes ----------------
  always_comb begin
    rom_byte = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (rom_idx == 3'(i)) rom_byte = ID_VALUE[8*i +: 8];
    end
  end

  always_comb begin
    mem_byte = 8'h00;
    if (ptr >= STOP_ADDR) begin
      mem_byte = 8'hFF;
    end else if (ptr < MEM_LIMIT) begin
      mem_byte = ram_rdata;
    end else begin
      for (int i = 0; i < RTC_BYTES; i++) begin
        if (rtc_rel == 16'(i)) mem_byte = rtc_val[8*i +: 8];
      end
    end
  end

  always_comb begin
    unique case (st)
      S_RDROM: tx_byte = rom_byte;
      S_RDMEM: tx_byte = mem_byte;
      S_TXA1:  tx_byte = ta1;
      S_TXA2:  tx_byte = ta2;
      S_TXEND: tx_byte = 8'(end_ofs);
      S_RDPAD: tx_byte = pad_done ? 8'hFF : pad_rdata;
      S_COPY:  tx_byte = 8'h00;
      S_CPST:  tx_byte = auth_ok ? 8'hFF : 8'h00;
      default: tx_byte = 8'hFF;
    endcase
  end

  // ---------------- next state ----------------
  always_comb begin
    st_d       = st;
    rom_idx_d  = rom_idx;
    ptr_d      = ptr;
    ta1_d      = ta1;
    ta2_d      = ta2;
    end_ofs_d  = end_ofs;
    wofs_d     = wofs;
    op_rd_d    = op_rd;
    armed_d    = armed;
    auth_ok_d  = auth_ok;
    pad_done_d = pad_done;

    if (bus_rst) begin
      st_d      = S_ROMCMD;
      auth_ok_d = 1'b0;
    end else begin
      unique case (st)
        S_ROMCMD: if (rx_go) begin
          rom_idx_d = 3'd7;
          unique case (rx_byte)
            OP_ROM_READ:  st_d = S_RDROM;
            OP_ROM_MATCH: st_d = S_MTROM;
            OP_ROM_SKIP:  st_d = S_MEMCMD;
            default:      st_d = S_IDLE;
          endcase
        end
        S_RDROM: if (tx_go) begin
          if (rom_idx == 3'd0) st_d = S_MEMCMD;
          else                 rom_idx_d = rom_idx - 3'd1;
        end
        S_MTROM: if (rx_go) begin
          if (rx_byte != rom_byte)  st_d = S_IDLE;
          else if (rom_idx == 3'd0) st_d = S_MEMCMD;
          else                      rom_idx_d = rom_idx - 3'd1;
        end
        S_MEMCMD: if (rx_go) begin
          unique case (rx_byte)
            OP_MEM_READ:  begin st_d = S_TA1; op_rd_d = 1'b1; end
            OP_PAD_WRITE: begin st_d = S_TA1; op_rd_d = 1'b0; end
            OP_PAD_READ:  st_d = S_TXA1;
            OP_PAD_COPY:  begin st_d = S_AU1; auth_ok_d = 1'b1; end
            default:      st_d = S_IDLE;
          endcase
        end
        S_TA1: if (rx_go) begin
          st_d = S_TA2;
          if (op_rd) ptr_d[7:0] = rx_byte;
          else       ta1_d      = rx_byte;
        end
        S_TA2: if (rx_go) begin
          if (op_rd) begin
            ptr_d[15:8] = rx_byte;
            st_d        = S_RDMEM;
          end else begin
            ta2_d     = rx_byte;
            wofs_d    = '0;
            end_ofs_d = '0;
            armed_d   = 1'b1;
            st_d      = S_WRPAD;
          end
        end
        S_RDMEM: if (tx_go && (ptr < STOP_ADDR)) begin
          ptr_d = ptr + 16'd1;
        end
        S_WRPAD: if (rx_go) begin
          end_ofs_d = wofs;
          wofs_d    = wofs + 1'b1;
        end
        S_TXA1: if (tx_go) st_d = S_TXA2;
        S_TXA2: if (tx_go) st_d = S_TXEND;
        S_TXEND: if (tx_go) begin
          st_d       = S_RDPAD;
          ptr_d      = '0;
          pad_done_d = 1'b0;
        end
        S_RDPAD: if (tx_go && !pad_done) begin
          if (ptr[PAD_AW-1:0] == end_ofs) pad_done_d = 1'b1;
          else                            ptr_d      = ptr + 16'd1;
        end
        S_AU1: if (rx_go) begin
          st_d = S_AU2;
          if (rx_byte != ta1) auth_ok_d = 1'b0;
        end
        S_AU2: if (rx_go) begin
          st_d = S_AU3;
          if (rx_byte != ta2) auth_ok_d = 1'b0;
        end
        S_AU3: if (rx_go) begin
          auth_ok_d = auth_ok && armed && (rx_byte == 8'(end_ofs));
          ptr_d     = '0;
          if (auth_ok && armed && (rx_byte == 8'(end_ofs))) begin
            armed_d = 1'b0;
            st_d    = S_COPY;
          end else begin
            st_d = S_CPST;
          end
        end
        S_COPY: begin
          if (ptr[PAD_AW-1:0] == end_ofs) st_d  = S_CPST;
          else                            ptr_d = ptr + 16'd1;
        end
        S_CPST: if (tx_go) auth_ok_d = 1'b0;
        default: ;
      endcase
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rom_idx  <= 3'd0;
      ptr      <= 16'h0000;
      ta1      <= 8'h00;
      ta2      <= 8'h00;
      end_ofs  <= '0;
      wofs     <= '0;
      op_rd    <= 1'b0;
      armed    <= 1'b0;
      auth_ok  <= 1'b0;
      pad_done <= 1'b0;
    end else begin
      st       <= st_d;
      rom_idx  <= rom_idx_d;
      ptr      <= ptr_d;
      ta1      <= ta1_d;
      ta2      <= ta2_d;
      end_ofs  <= end_ofs_d;
      wofs     <= wofs_d;
      op_rd    <= op_rd_d;
      armed    <= armed_d;
      auth_ok  <= auth_ok_d;
      pad_done <= pad_done_d;
    end
  end

endmodule

// File: rtl/owe_engine_checker.sv
module owe_engine_checker
  import owe_pkg::*;
#(
  parameter int          RTC_BYTES = 5,
  parameter logic [15:0] STOP_ADDR = 16'h021F,
  localparam int         RTC_W     = 8 * RTC_BYTES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rst,
  input logic             rx_vld,
  input logic [7:0]       rx_byte,
  input logic             tx_req,
  input logic [7:0]       tx_byte,
  input logic             tick,
  input eng_state_e       st,
  input logic [15:0]      ptr,
  input logic             armed,
  input logic [RTC_W-1:0] rtc_val,
  input logic             rtc_we
);

  localparam logic [RTC_W-1:0] ONE = 1;

  // R1
  reset_to_romcmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> st == S_ROMCMD);

  // R4
  bad_rom_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ROMCMD && rx_vld && !bus_rst && rx_byte != OP_ROM_READ &&
     rx_byte != OP_ROM_MATCH && rx_byte != OP_ROM_SKIP) |=> st == S_IDLE);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> tx_byte == 8'hFF);

  // R6
  read_top_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDMEM && ptr >= STOP_ADDR) |-> tx_byte == 8'hFF);

  // R6
  read_top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDMEM && ptr >= STOP_ADDR && !bus_rst) |=> ptr == $past(ptr));

  // R10
  status_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CPST && tx_req && !bus_rst) |=> tx_byte == 8'h00);

  // R11
  unarmed_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AU3 && rx_vld && !bus_rst && !armed) |=> st == S_CPST);

  // R12
  clock_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rtc_we) |=> rtc_val == $past(rtc_val) + ONE);

endmodule

bind onewire_cmd_engine owe_engine_checker #(
  .RTC_BYTES (RTC_BYTES),
  .STOP_ADDR (STOP_ADDR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_rst (bus_rst),
  .rx_vld  (rx_vld),
  .rx_byte (rx_byte),
  .tx_req  (tx_req),
  .tx_byte (tx_byte),
  .tick    (tick),
  .st      (st),
  .ptr     (ptr),
  .armed   (armed),
  .rtc_val (rtc_val),
  .rtc_we  (rtc_we)
);

// File: tb/onewire_cmd_engine_test.sv
`timescale 1ns/1ps
module onewire_cmd_engine_test;

  localparam logic [63:0] ID = 64'h2A5B17C39904E16F;

  logic       clk = 1'b0;
  logic       rst_n, bus_rst, rx_vld, tx_req, tick;
  logic [7:0] rx_byte, tx_byte;

  always #4 clk = ~clk;

  onewire_cmd_engine #(.ID_VALUE(ID)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_vld(rx_vld),
    .rx_byte(rx_byte), .tx_req(tx_req), .tx_byte(tx_byte), .tick(tick)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  logic [7:0]  mem_m [512];
  bit          known [512];
  logic [7:0]  pad_m [32];
  logic [7:0]  wbuf [64];
  logic [39:0] rtc_m = '0;
  logic [15:0] ta_m = '0;
  int          end_m = 0;
  bit          armed_m = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic breset();
    bus_rst = 1'b1; cyc(1); bus_rst = 1'b0;
  endtask

  task automatic send(logic [7:0] b);
    rx_vld = 1'b1; rx_byte = b; cyc(1); rx_vld = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b);
    b = tx_byte; tx_req = 1'b1; cyc(1); tx_req = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(1); tick = 1'b0;
      rtc_m = rtc_m + 40'd1;
    end
  endtask

  task automatic skip();
    breset(); send(8'hCC);
  endtask

  function automatic logic [8:0] exp_mem(int a);
    if (a >= 'h21F) return {1'b1, 8'hFF};
    if (a < 512) return {known[a], mem_m[a]};
    if (a >= 'h202 && a <= 'h206) return {1'b1, rtc_m[8*(a-'h202) +: 8]};
    return {1'b1, 8'h00};
  endfunction

  task automatic wr_pad(logic [15:0] ta, int n);
    skip(); send(8'h0F); send(ta[7:0]); send(ta[15:8]);
    for (int i = 0; i < n; i++) begin
      send(wbuf[i]);
      pad_m[i % 32] = wbuf[i];
    end
    end_m = (n == 0) ? 0 : (n - 1) % 32;
    ta_m = ta; armed_m = 1;
  endtask

  task automatic rd_pad(string tag);
    logic [7:0] b;
    skip(); send(8'hAA);
    recv(b); chk({tag, " TA1"}, b, ta_m[7:0]);
    recv(b); chk({tag, " TA2"}, b, ta_m[15:8]);
    recv(b); chk({tag, " end offset"}, b, 8'(end_m));
    for (int i = 0; i <= end_m; i++) begin
      recv(b); chk({tag, " pad byte"}, b, pad_m[i]);
    end
    recv(b); chk({tag, " past end"}, b, 8'hFF);
  endtask

  task automatic do_copy(logic [7:0] a1, logic [7:0] a2, logic [7:0] e, string tag);
    logic [7:0] b;
    bit ok;
    ok = armed_m && a1 == ta_m[7:0] && a2 == ta_m[15:8] && e == 8'(end_m);
    skip(); send(8'h55); send(a1); send(a2); send(e);
    cyc(40);
    recv(b); chk({tag, " status"}, b, ok ? 8'hFF : 8'h00);
    recv(b); chk("R10 status after first", b, 8'h00);
    if (ok) begin
      for (int i = 0; i <= end_m; i++) begin
        int a;
        a = int'(ta_m) + i;
        if (a < 512) begin mem_m[a] = pad_m[i]; known[a] = 1; end
        else if (a >= 'h202 && a <= 'h206) rtc_m[8*(a-'h202) +: 8] = pad_m[i];
      end
      armed_m = 0;
    end
  endtask

  task automatic rd_mem(int a, int n, string tag);
    logic [7:0] b;
    logic [8:0] e;
    skip(); send(8'hF0); send(8'(a)); send(8'(a >> 8));
    for (int i = 0; i < n; i++) begin
      recv(b);
      e = exp_mem(a);
      if (e[8]) chk(tag, b, e[7:0]);
      if (a < 'h21F) a++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd4711));
    for (int i = 0; i < 512; i++) begin known[i] = 0; mem_m[i] = '0; end
    for (int i = 0; i < 32; i++) pad_m[i] = '0;
    rst_n = 1'b0; bus_rst = 0; rx_vld = 0; tx_req = 0; tick = 0; rx_byte = 0;
    cyc(3); rst_n = 1'b1; cyc(1);

    // R1: idle after reset, bytes ignored
    chk("R1 reset tx", tx_byte, 8'hFF);
    send(8'hCC); send(8'hAA);
    recv(b); chk("R1 no bus reset yet", b, 8'hFF);

    // R2: read identity, then memory command
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'h10 + i);
    wr_pad(16'h0123, 4);
    breset(); send(8'h33);
    for (int i = 0; i < 8; i++) begin
      recv(b); chk("R2 identity byte", b, ID[8*(7-i) +: 8]);
    end
    send(8'hAA); recv(b); chk("R2 memory command after identity", b, 8'h23);

    // R3: match ok / mismatch
    breset(); send(8'h55);
    for (int i = 0; i < 8; i++) send(ID[8*(7-i) +: 8]);
    send(8'hAA); recv(b); chk("R3 match accepted", b, 8'h23);
    breset(); send(8'h55);
    for (int i = 0; i < 8; i++) send(i == 3 ? ~ID[8*(7-i) +: 8] : ID[8*(7-i) +: 8]);
    send(8'hAA); recv(b); chk("R3 mismatch idles", b, 8'hFF);

    // R4: unknown codes
    breset(); send(8'hF0); send(8'hAA);
    recv(b); chk("R4 unknown addressing code", b, 8'hFF);
    skip(); send(8'h99); send(8'hAA);
    recv(b); chk("R4 unknown memory code", b, 8'hFF);

    // R1: reset mid-stream restarts decoding
    skip(); send(8'hF0); send(8'h00); send(8'h00); recv(b);
    breset(); send(8'h33);
    recv(b); chk("R1 reset mid read", b, ID[63:56]);

    // R8 / R7: pad read and wrap
    rd_pad("R8");
    for (int i = 0; i < 35; i++) wbuf[i] = 8'($urandom);
    wr_pad(16'h0040, 35);
    rd_pad("R7 wrap");

    // R9 / R10 / R11
    for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
    wr_pad(16'h0100, 8);
    do_copy(8'h00, 8'h01, 8'h07, "R9 copy ok");
    rd_mem('h0FE, 12, "R5 read after copy");
    do_copy(8'h00, 8'h01, 8'h07, "R11 repeat copy");
    for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
    wr_pad(16'h0100, 4);
    do_copy(8'h00, 8'h01, 8'h04, "R10 bad auth");
    rd_mem('h100, 6, "R9 memory unchanged");

    // R12 / R5: clock
    ticks(300);
    rd_mem('h200, 8, "R12 clock count read");
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF; wbuf[3] = 8'hFF; wbuf[4] = 8'h00;
    wr_pad(16'h0202, 5);
    do_copy(8'h02, 8'h02, 8'h04, "R12 clock load");
    ticks(1);
    rd_mem('h202, 5, "R12 carry ripple");

    // R6: top of read window
    rd_mem('h21C, 7, "R6 top of window");
    rd_mem('h8000, 3, "R6 high address");

    // random writes and copies
    for (int it = 0; it < 24; it++) begin
      int n, a;
      bit bad;
      n = int'($urandom_range(1, 32));
      a = int'($urandom_range(0, 'h1DF));
      bad = ($urandom_range(0, 3) == 0);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_pad(16'(a), n);
      if (bad) do_copy(8'(a) ^ 8'h01, 8'(a >> 8), 8'(n - 1), "R9 random reject");
      else     do_copy(8'(a), 8'(a >> 8), 8'(n - 1), "R9 random copy");
      rd_mem(a, n + 1, "R5 random read");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule